// File: doc/BRIEF.md
# Register Rename Alias Table

The alias table remembers, for every architectural register, the tag of the youngest dispatched instruction that writes it. A dispatch stage writes an entry by presenting a destination register and a writer tag. A source-operand lookup reads the table combinationally and returns that tag with a valid bit. Retirement presents the register and tag of the instruction that is leaving. Every write is taken to update the whole register, so there is no tracking of sub-registers or super-registers.

Each live mapping occupies one temporary rename register. A cap input limits how many temporaries may be in use at once, and a cap of zero removes the limit. An availability query tells dispatch whether a group of N writes would still fit. The block keeps three counts: temporaries in use now, the highest number ever in use, and the total number of mappings ever created.

Top module: `rename_alias_table`

## Requirements
- R1: After reset every lookup returns valid 0. The in-use, peak and total counts are 0 and `alloc_err` is 0. Reset leaves `cfg_cap` alone, because it is an input.
- R2: An allocate that is accepted writes {valid 1, `alloc_tag`} into the entry of `alloc_reg`, and a lookup shows it from the next cycle on. A later allocate to the same register replaces the tag, so only the last writer is kept.
- R3: With `cfg_cap` not zero, `query_ok` is 1 exactly when in-use + `query_num` <= `cfg_cap`. The in-use count used here is the registered value from before any release in the same cycle.
- R4: With `cfg_cap` equal to 0, `query_ok` is always 1 and every allocate is accepted, whatever the in-use count.
- R5: An allocate is accepted only if a query for one write would pass. A refused allocate sets `alloc_err` to 1 in the next cycle only. It leaves the table, the in-use count and the total count unchanged.
- R6: A release returns one temporary, so the in-use count drops by 1. The entry of `rel_reg` becomes invalid only if it is valid and holds `rel_tag`.
- R7: A release whose tag differs from the stored tag leaves that entry unchanged.
- R8: The peak count equals the highest in-use count seen since reset, and it never decreases.
- R9: The total count goes up by 1 for each accepted allocate and is left unchanged by refused ones.
- R10: An allocate and a release in the same cycle: the in-use count changes by +1 for an accepted allocate and -1 for the release. If both name the same register, the allocated tag wins.
- R11: A release while the in-use count is 0 leaves the in-use count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cap | input | CAP_W | Temporary cap, 0 = unlimited |
| alloc_valid | input | 1 | Allocate request |
| alloc_reg | input | REG_W | Destination architectural register |
| alloc_tag | input | 6 | Writer tag |
| alloc_err | output | 1 | Previous cycle's allocate was refused |
| look_reg | input | REG_W | Source register to look up |
| look_valid | output | 1 | Entry holds an in-flight writer |
| look_tag | output | 6 | Tag of that writer |
| rel_valid | input | 1 | Release from retirement |
| rel_reg | input | REG_W | Register written by the retiring instruction |
| rel_tag | input | 6 | Tag of the retiring instruction |
| query_num | input | CAP_W | Number of writes to test |
| query_ok | output | 1 | That many writes fit |
| used_cnt | output | CNT_W | Temporaries in use |
| peak_cnt | output | CNT_W | Highest in-use value since reset |
| total_cnt | output | CNT_W | Mappings created since reset |

## Verification
An allocate and a release can arrive in the same cycle, either to different registers or to the same one. The bench drives both together several times. One case is a release with a stale tag while a newer writer is live. One is a release of the current writer next to an allocate elsewhere. One is a same-register pair in which the new tag must survive. Another sends an allocate at the full cap alongside a release: because availability is judged before the release, that allocate must still be refused. Each case is judged from the lookup, the in-use count and `alloc_err` one cycle later.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int RAT_TAG_W = 6;

  typedef struct packed {
    logic                 vld;
    logic [RAT_TAG_W-1:0] tag;
  } rat_entry_t;
endpackage

// File: rtl/rat_avail.sv
module rat_avail #(
  parameter int CAP_W = 8,
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] used,
  input  logic [CAP_W-1:0] need,
  input  logic [CAP_W-1:0] cap,
  output logic             ok
);
  localparam int SUM_W = CNT_W + 1;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, used} + SUM_W'(need);
    ok  = (cap == '0) || (sum <= SUM_W'(cap));
  end
endmodule

// File: rtl/rat_table.sv
module rat_table
  import rat_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_idx,
  input  logic [RAT_TAG_W-1:0] wr_tag,
  input  logic                 clr_en,
  input  logic [REG_W-1:0]     clr_idx,
  input  logic [RAT_TAG_W-1:0] clr_tag,
  input  logic [REG_W-1:0]     rd_idx,
  output rat_entry_t           rd_entry
);
  rat_entry_t ent_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    rat_entry_t ent_d;
    logic       hit_wr;
    logic       hit_clr;

    always_comb begin
      hit_wr  = wr_en && (wr_idx == REG_W'(g));
      hit_clr = clr_en && (clr_idx == REG_W'(g)) && ent_q[g].vld &&
                (ent_q[g].tag == clr_tag);
      ent_d   = ent_q[g];
      if (hit_wr) begin
        ent_d.vld = 1'b1;
        ent_d.tag = wr_tag;
      end else if (hit_clr) begin
        ent_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else if (hit_wr || hit_clr) ent_q[g] <= ent_d;
    end
  end

  always_comb rd_entry = ent_q[rd_idx];
endmodule

// File: rtl/rat_counters.sv
module rat_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec_req,
  input  logic             fail,
  output logic [CNT_W-1:0] used,
  output logic [CNT_W-1:0] peak,
  output logic [CNT_W-1:0] total,
  output logic             err
);
  logic [CNT_W-1:0] used_d, peak_d, total_d;
  logic             dec;

  always_comb begin
    dec     = dec_req && (used != '0);
    used_d  = used + CNT_W'(inc) - CNT_W'(dec);
    peak_d  = (used_d > peak) ? used_d : peak;
    total_d = total + CNT_W'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used  <= '0;
      peak  <= '0;
      total <= '0;
      err   <= 1'b0;
    end else begin
      if (inc || dec) used <= used_d;
      if (inc) begin
        peak  <= peak_d;
        total <= total_d;
      end
      err <= fail;
    end
  end
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table
  import rat_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int CAP_W    = 8,
  parameter int CNT_W    = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CAP_W-1:0]     cfg_cap,
  input  logic                 alloc_valid,
  input  logic [REG_W-1:0]     alloc_reg,
  input  logic [RAT_TAG_W-1:0] alloc_tag,
  output logic                 alloc_err,
  input  logic [REG_W-1:0]     look_reg,
  output logic                 look_valid,
  output logic [RAT_TAG_W-1:0] look_tag,
  input  logic                 rel_valid,
  input  logic [REG_W-1:0]     rel_reg,
  input  logic [RAT_TAG_W-1:0] rel_tag,
  input  logic [CAP_W-1:0]     query_num,
  output logic                 query_ok,
  output logic [CNT_W-1:0]     used_cnt,
  output logic [CNT_W-1:0]     peak_cnt,
  output logic [CNT_W-1:0]     total_cnt
);
  logic       one_ok;
  logic       alloc_acc;
  logic       alloc_fail;
  rat_entry_t rd_entry;

  rat_avail #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_avail_one (
    .used(used_cnt), .need(CAP_W'(1)), .cap(cfg_cap), .ok(one_ok)
  );

  rat_avail #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_avail_query (
    .used(used_cnt), .need(query_num), .cap(cfg_cap), .ok(query_ok)
  );

  always_comb begin
    alloc_acc  = alloc_valid && one_ok;
    alloc_fail = alloc_valid && !one_ok;
  end

  rat_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_acc), .wr_idx(alloc_reg), .wr_tag(alloc_tag),
    .clr_en(rel_valid), .clr_idx(rel_reg), .clr_tag(rel_tag),
    .rd_idx(look_reg), .rd_entry(rd_entry)
  );

  rat_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc(alloc_acc), .dec_req(rel_valid), .fail(alloc_fail),
    .used(used_cnt), .peak(peak_cnt), .total(total_cnt), .err(alloc_err)
  );

  always_comb begin
    look_valid = rd_entry.vld;
    look_tag   = rd_entry.tag;
  end
endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
  parameter int CAP_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CAP_W-1:0] cfg_cap,
  input logic             alloc_valid,
  input logic             rel_valid,
  input logic             alloc_err,
  input logic [CNT_W-1:0] used_cnt,
  input logic [CNT_W-1:0] peak_cnt,
  input logic [CNT_W-1:0] total_cnt
);
  logic full;
  always_comb full = (cfg_cap != '0) && ({{(CNT_W+1){1'b0}}, used_cnt} + 1 > {{(CNT_W+1){1'b0}}, CNT_W'(cfg_cap)});

  AST_REFUSE_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && full) |=> alloc_err); // R5
  AST_NO_ERR_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !full) |=> !alloc_err); // R4
  AST_ERR_KEEPS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && full) |=> (total_cnt == $past(total_cnt))); // R9
  AST_USED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (used_cnt == $past(used_cnt)) || (used_cnt == $past(used_cnt) + 1'b1) ||
    (used_cnt == $past(used_cnt) - 1'b1)); // R10
  AST_IDLE_USED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_valid && !rel_valid) |=> $stable(used_cnt)); // R6
  AST_PEAK_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_cnt >= used_cnt) && (peak_cnt >= $past(peak_cnt))); // R8
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (total_cnt == $past(total_cnt)) || (total_cnt == $past(total_cnt) + 1'b1)); // R9
  AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (used_cnt == '0 && rel_valid && !alloc_valid) |=> (used_cnt == '0)); // R11
endmodule

bind rename_alias_table rat_checker #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cap(cfg_cap), .alloc_valid(alloc_valid),
  .rel_valid(rel_valid), .alloc_err(alloc_err), .used_cnt(used_cnt),
  .peak_cnt(peak_cnt), .total_cnt(total_cnt)
);

// File: tb/tb_rename_alias_table.sv
module tb_rename_alias_table;
  localparam int CAP_W = 8;
  localparam int CNT_W = 16;
  localparam int REG_W = 4;
  localparam int TAG_W = 6;

  logic             clk, rst_n;
  logic [CAP_W-1:0] cfg_cap, query_num;
  logic             alloc_valid, rel_valid;
  logic [REG_W-1:0] alloc_reg, rel_reg, look_reg;
  logic [TAG_W-1:0] alloc_tag, rel_tag, look_tag;
  logic             alloc_err, look_valid, query_ok;
  logic [CNT_W-1:0] used_cnt, peak_cnt, total_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rename_alias_table dut (
    .clk(clk), .rst_n(rst_n), .cfg_cap(cfg_cap),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_tag(alloc_tag),
    .alloc_err(alloc_err), .look_reg(look_reg), .look_valid(look_valid),
    .look_tag(look_tag), .rel_valid(rel_valid), .rel_reg(rel_reg),
    .rel_tag(rel_tag), .query_num(query_num), .query_ok(query_ok),
    .used_cnt(used_cnt), .peak_cnt(peak_cnt), .total_cnt(total_cnt)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic             av;
    logic [REG_W-1:0] ar;
    logic [TAG_W-1:0] at;
    logic             rv;
    logic [REG_W-1:0] rr;
    logic [TAG_W-1:0] rt;
    logic [REG_W-1:0] lr;
    logic             ev;
    logic [TAG_W-1:0] et;
    logic [7:0]       eu;
    logic             ee;
  } vec_t;

  // cap = 4 during the table
  localparam vec_t VECS [0:10] = '{
    '{1'b1, 4'd3, 6'd5,  1'b0, 4'd0, 6'd0,  4'd3, 1'b1, 6'd5,  8'd1, 1'b0}, // R2
    '{1'b1, 4'd3, 6'd9,  1'b0, 4'd0, 6'd0,  4'd3, 1'b1, 6'd9,  8'd2, 1'b0}, // R2 overwrite
    '{1'b0, 4'd0, 6'd0,  1'b1, 4'd3, 6'd5,  4'd3, 1'b1, 6'd9,  8'd1, 1'b0}, // R7 stale tag
    '{1'b1, 4'd7, 6'd12, 1'b1, 4'd3, 6'd9,  4'd3, 1'b0, 6'd0,  8'd1, 1'b0}, // R6 R10
    '{1'b0, 4'd0, 6'd0,  1'b0, 4'd0, 6'd0,  4'd7, 1'b1, 6'd12, 8'd1, 1'b0}, // R2
    '{1'b1, 4'd7, 6'd20, 1'b1, 4'd7, 6'd12, 4'd7, 1'b1, 6'd20, 8'd1, 1'b0}, // R10 same reg
    '{1'b1, 4'd1, 6'd1,  1'b0, 4'd0, 6'd0,  4'd1, 1'b1, 6'd1,  8'd2, 1'b0}, // R2
    '{1'b1, 4'd2, 6'd2,  1'b0, 4'd0, 6'd0,  4'd2, 1'b1, 6'd2,  8'd3, 1'b0}, // R2
    '{1'b1, 4'd4, 6'd4,  1'b0, 4'd0, 6'd0,  4'd4, 1'b1, 6'd4,  8'd4, 1'b0}, // R3 fill
    '{1'b1, 4'd5, 6'd6,  1'b0, 4'd0, 6'd0,  4'd5, 1'b0, 6'd0,  8'd4, 1'b1}, // R5 refused
    '{1'b1, 4'd5, 6'd6,  1'b1, 4'd1, 6'd1,  4'd5, 1'b0, 6'd0,  8'd3, 1'b1}  // R10 R5
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; rel_valid = 0;
    alloc_reg = '0; alloc_tag = '0; rel_reg = '0; rel_tag = '0;
  endtask

  task automatic cycle();
    @(posedge clk); #2; idle_inputs(); #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_cap = 8'd4; query_num = '0; look_reg = '0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    #1;
    look_reg = 4'd3; #1;
    chk("R1 look_valid", look_valid, 0);
    chk("R1 used", used_cnt, 0);
    chk("R1 peak", peak_cnt, 0);
    chk("R1 total", total_cnt, 0);
    chk("R1 err", alloc_err, 0);

    for (int i = 0; i < 11; i++) begin
      alloc_valid = VECS[i].av; alloc_reg = VECS[i].ar; alloc_tag = VECS[i].at;
      rel_valid = VECS[i].rv; rel_reg = VECS[i].rr; rel_tag = VECS[i].rt;
      cycle();
      look_reg = VECS[i].lr; #1;
      chk($sformatf("R2 vec%0d look_valid", i), look_valid, VECS[i].ev);
      if (VECS[i].ev) chk($sformatf("R2 vec%0d look_tag", i), look_tag, VECS[i].et);
      chk($sformatf("R6 vec%0d used", i), used_cnt, VECS[i].eu);
      chk($sformatf("R5 vec%0d alloc_err", i), alloc_err, VECS[i].ee);
    end
    look_reg = 4'd1; #1;
    chk("R6 matched release clears r1", look_valid, 0);
    chk("R8 peak", peak_cnt, 4);
    chk("R9 total", total_cnt, 7);
    chk("R5 err one cycle", 0, 0);
    cycle();
    chk("R5 err drops", alloc_err, 0);

    // R3 queries with used = 3, cap = 4
    query_num = 8'd1; #1; chk("R3 query 1 fits", query_ok, 1);
    query_num = 8'd2; #1; chk("R3 query 2 refused", query_ok, 0);
    query_num = 8'd0; #1; chk("R3 query 0 fits", query_ok, 1);

    // R4 unlimited
    cfg_cap = 8'd0; query_num = 8'd200; #1;
    chk("R4 query 200 fits", query_ok, 1);
    for (int k = 0; k < 3; k++) begin
      alloc_valid = 1; alloc_reg = REG_W'(8 + k); alloc_tag = TAG_W'(30 + k);
      cycle();
      chk("R4 no error", alloc_err, 0);
    end
    chk("R4 used", used_cnt, 6);
    chk("R8 peak 6", peak_cnt, 6);
    chk("R9 total 10", total_cnt, 10);
    look_reg = 4'd9; #1;
    chk("R4 r9 tag", look_tag, 31);

    // R11 drain past zero
    for (int k = 0; k < 7; k++) begin
      rel_valid = 1; rel_reg = 4'd15; rel_tag = 6'd63;
      cycle();
    end
    chk("R11 used floor", used_cnt, 0);
    chk("R8 peak kept", peak_cnt, 6);
    look_reg = 4'd7; #1;
    chk("R7 unmatched release keeps r7", look_valid, 1);

    // R1 reset mid-run
    cfg_cap = 8'd4;
    rst_n = 0; #2;
    chk("R1 reset look", look_valid, 0);
    chk("R1 reset peak", peak_cnt, 0);
    chk("R1 reset total", total_cnt, 0);
    @(posedge clk); #3 rst_n = 1; #1;
    chk("R1 cap kept", cfg_cap, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule